// File: doc/BRIEF.md
# Two-Phase Early-Rejection Block Matcher

This block runs an exhaustive integer-pel motion search for a single 16x16 current block. It scores each candidate offset inside a square reference window by its sum of absolute differences (SAD), and it returns the offset with the lowest score together with that score. The cost of each candidate is split into two parts. A wide array adds up the absolute differences on the even rows of the block in one cycle. A narrow unit then adds the odd rows, one row per cycle, but only when the even-row partial is still below the best full score found so far.

The search starts by scoring a predicted vector, which seeds the running minimum, so that the even-row test rejects candidates from the first scanned offset onward. The reference window is read one column at a time. Columns shift through a register so that horizontally adjacent candidates share fetched pixels. The wide array moves on to the next candidate while the narrow unit finishes the previous survivor. A one-entry waiting slot sits between the two units.

Top module: `et_sad_search`

## Requirements
- R1: After done, `best_sad` equals the smallest full SAD over the predicted offset and every in-range candidate, and `best_x`/`best_y` give that candidate's offset. Current pixel (r,c) sits at `cur_blk` bits `(r*BLK+c)*8 +: 8` and must be held stable during a search.
- R2: With `srch_rng` = s (1..RNG, latched at start), the scanned offsets are dx, dy in [-s, s-1]. No other offset is returned except the predicted one.
- R3: For candidate (dx,dy), block pixel (r,c) is compared with window pixel x=c+dx+RNG, y=r+dy+RNG. The address `ref_x`/`ref_y` returns, in the same cycle, the column `ref_col`, whose bits `k*8 +: 8` hold window pixel (ref_x, ref_y+k). While fetching, `ref_x` < WIN and `ref_y`+BLK <= WIN, with WIN = BLK+2*RNG-1.
- R4: After reset, `best_sad` reads 65535 and the vector reads (0,0). Within a search the reported minimum never increases.
- R5: After reset `done` is low. `done` pulses for exactly one cycle once every candidate and any pending odd-row work are finished. The results then hold until the next start.
- R6: A candidate whose even-row SAD is not below the stored minimum is dropped without odd-row work. When the predicted offset scores 0, the search ends within 2s(2s+BLK-1)+40 cycles of start.
- R7: The predicted offset is scored first, wins every tie, and competes even when it lies outside the scanned range.
- R8: Among scanned candidates with equal full SAD, the one with the smaller dy wins, and for equal dy the one with the smaller dx wins.
- R9: At most one survivor waits for the odd-row unit. A second survivor stalls fetching until the slot empties. A waiting survivor is re-tested against the minimum when the odd-row unit picks it up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| pred_x | input | MVW | Predicted horizontal offset, signed |
| pred_y | input | MVW | Predicted vertical offset, signed |
| srch_rng | input | RW | Search half-range s, 1..RNG |
| cur_blk | input | BLK*BLK*8 | Current block pixels, row-major |
| ref_x | output | XW | Window column being read |
| ref_y | output | XW | Window top row of the column being read |
| ref_col | input | BLK*8 | BLK window pixels of the addressed column, same cycle |
| best_x | output | MVW | Winning horizontal offset, signed |
| best_y | output | MVW | Winning vertical offset, signed |
| best_sad | output | 16 | Winning full SAD |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, every cycle, that the running minimum never rises within a search, that fetch addresses stay inside the window, and that a stalled candidate is held unchanged. They also check that nothing is pushed into an occupied waiting slot, that done is a single pulse raised only with both units idle, and that results stay frozen while idle. Only the bench's scenarios can show that the returned vector and score are the true minimum. The same holds for the tie ordering between the predicted offset and the raster scan, for the effect of a reduced range, and for early rejection shortening the search. The bench shows these by comparing against an exhaustive model on random frames, frames with known motion, flat frames and frames built to produce ties.

// File: rtl/et_sad_pkg.sv
package et_sad_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRED,
      ST_PWAIT,
      ST_SCAN,
      ST_DRAIN
   } scan_st_e;
endpackage

// File: rtl/et_sad_rows.sv
module et_sad_rows #(
   parameter int PW = 8,
   parameter int N  = 16,
   parameter int SW = 16
) (
   input  logic [N*PW-1:0] a,
   input  logic [N*PW-1:0] b,
   output logic [SW-1:0]   sum
);
   if (N < 1 || PW < 1) begin : g_bad
      $error("et_sad_rows: N and PW must be positive");
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < N; i++) begin
         logic [PW-1:0] x, y, d;
         x = a[i*PW +: PW];
         y = b[i*PW +: PW];
         d = (x > y) ? (x - y) : (y - x);
         sum = sum + SW'(d);
      end
   end
endmodule

// File: rtl/et_sad_serial.sv
module et_sad_serial #(
   parameter int PW  = 8,
   parameter int BLK = 16,
   parameter int MVW = 4,
   parameter int SW  = 16,
   localparam int HALF = BLK / 2,
   localparam int COLW = BLK * PW,
   localparam int HW   = HALF * BLK * PW,
   localparam int KW   = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  init,
   input  logic                  push,
   input  logic [SW-1:0]         push_part,
   input  logic signed [MVW-1:0] push_x,
   input  logic signed [MVW-1:0] push_y,
   input  logic [HW-1:0]         push_odd,
   input  logic [HW-1:0]         cur_odd,
   output logic                  slot_full,
   output logic                  busy,
   output logic [SW-1:0]         min_sad,
   output logic signed [MVW-1:0] best_x,
   output logic signed [MVW-1:0] best_y
);
   logic                  slot_v, act_v;
   logic [SW-1:0]         slot_part, act_sum, min_q, row_sad, full;
   logic signed [MVW-1:0] slot_x, slot_y, act_x, act_y, bx, by;
   logic [HW-1:0]         slot_odd, act_odd;
   logic [KW-1:0]         act_k;
   logic [COLW-1:0]       cur_row, ref_row;
   logic                  take;

   assign cur_row = cur_odd[act_k*COLW +: COLW];
   assign ref_row = act_odd[act_k*COLW +: COLW];

   et_sad_rows #(.PW(PW), .N(BLK), .SW(SW)) u_row (
      .a(cur_row), .b(ref_row), .sum(row_sad));

   assign full = act_sum + row_sad;
   assign take = slot_v && !act_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_v <= 1'b0;  act_v <= 1'b0;
         slot_part <= '0; slot_x <= '0; slot_y <= '0; slot_odd <= '0;
         act_sum <= '0;   act_x <= '0;  act_y <= '0;  act_odd <= '0;
         act_k <= '0;     min_q <= '1;  bx <= '0;     by <= '0;
      end else if (init) begin
         slot_v <= 1'b0;
         act_v  <= 1'b0;
         min_q  <= '1;
      end else begin
         if (take) begin
            slot_v <= 1'b0;
            if (slot_part < min_q) begin
               act_v   <= 1'b1;
               act_sum <= slot_part;
               act_x   <= slot_x;
               act_y   <= slot_y;
               act_odd <= slot_odd;
               act_k   <= '0;
            end
         end
         if (push) begin
            slot_v    <= 1'b1;
            slot_part <= push_part;
            slot_x    <= push_x;
            slot_y    <= push_y;
            slot_odd  <= push_odd;
         end
         if (act_v) begin
            act_sum <= full;
            act_k   <= act_k + 1'b1;
            if (act_k == KW'(HALF - 1)) begin
               act_v <= 1'b0;
               if (full < min_q) begin
                  min_q <= full;
                  bx    <= act_x;
                  by    <= act_y;
               end
            end
         end
      end
   end

   assign slot_full = slot_v;
   assign busy      = act_v;
   assign min_sad   = min_q;
   assign best_x    = bx;
   assign best_y    = by;

   // R9: the wide array never overwrites a waiting survivor
   assert_slot_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !slot_v);
   // R4: the running minimum only falls inside a search
   assert_min_nonincr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !init |=> (min_q <= $past(min_q)));
endmodule

// File: rtl/et_sad_search.sv
module et_sad_search
   import et_sad_pkg::*;
#(
   parameter int PW  = 8,
   parameter int BLK = 16,
   parameter int RNG = 8,
   localparam int WIN = BLK + 2 * RNG - 1,
   localparam int XW  = $clog2(WIN),
   localparam int MVW = $clog2(RNG) + 1,
   localparam int RW  = $clog2(RNG) + 1,
   localparam int SW  = $clog2(BLK * BLK * ((1 << PW) - 1) + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic signed [MVW-1:0] pred_x,
   input  logic signed [MVW-1:0] pred_y,
   input  logic [RW-1:0]         srch_rng,
   input  logic [BLK*BLK*PW-1:0] cur_blk,
   output logic [XW-1:0]         ref_x,
   output logic [XW-1:0]         ref_y,
   input  logic [BLK*PW-1:0]     ref_col,
   output logic signed [MVW-1:0] best_x,
   output logic signed [MVW-1:0] best_y,
   output logic [SW-1:0]         best_sad,
   output logic                  done
);
   localparam int HALF = BLK / 2;
   localparam int COLW = BLK * PW;
   localparam int HW   = HALF * BLK * PW;
   localparam int CW   = XW + 1;

   if (BLK < 4 || (BLK % 2) != 0) begin : g_bad_blk
      $error("et_sad_search: BLK must be even and at least 4");
   end
   if (RNG < 2) begin : g_bad_rng
      $error("et_sad_search: RNG must be at least 2");
   end
   if (PW < 1) begin : g_bad_pw
      $error("et_sad_search: PW must be positive");
   end

   scan_st_e              st;
   logic [COLW-1:0]       sr [BLK];
   logic [CW-1:0]         col, row, col_first, col_last, row_last;
   logic [RW-1:0]         s_q;
   logic                  cand_vld;
   logic signed [MVW-1:0] cand_x, cand_y;
   logic [HW-1:0]         ref_even, cur_even, ref_odd, cur_odd;
   logic [SW-1:0]         part_sad, min_sad;
   logic                  slot_full, busy, survive, push, stall;
   logic                  fetching, fetch, quiet, init;

   for (genvar r = 0; r < HALF; r++) begin : g_row
      for (genvar c = 0; c < BLK; c++) begin : g_col
         assign ref_even[(r*BLK+c)*PW +: PW] = sr[c][(2*r)*PW +: PW];
         assign ref_odd [(r*BLK+c)*PW +: PW] = sr[c][(2*r+1)*PW +: PW];
         assign cur_even[(r*BLK+c)*PW +: PW] = cur_blk[((2*r)*BLK+c)*PW +: PW];
         assign cur_odd [(r*BLK+c)*PW +: PW] = cur_blk[((2*r+1)*BLK+c)*PW +: PW];
      end
   end

   et_sad_rows #(.PW(PW), .N(HALF*BLK), .SW(SW)) u_par (
      .a(cur_even), .b(ref_even), .sum(part_sad));

   assign survive  = cand_vld && (part_sad < min_sad);
   assign stall    = survive && slot_full;
   assign push     = survive && !slot_full;
   assign fetching = (st == ST_PRED) || (st == ST_SCAN);
   assign fetch    = fetching && !stall;
   assign quiet    = !cand_vld && !slot_full && !busy;
   assign init     = (st == ST_IDLE) && start;
   assign ref_x    = fetching ? XW'(col) : '0;
   assign ref_y    = fetching ? XW'(row) : '0;

   always_ff @(posedge clk) begin
      if (fetch) begin
         for (int i = 0; i < BLK - 1; i++) sr[i] <= sr[i+1];
         sr[BLK-1] <= ref_col;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         col <= '0; row <= '0; col_first <= '0; col_last <= '0; row_last <= '0;
         s_q <= '0; cand_vld <= 1'b0; cand_x <= '0; cand_y <= '0; done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!stall) cand_vld <= 1'b0;
         if (fetch) begin
            cand_vld <= (col >= col_first + CW'(BLK - 1));
            cand_x   <= MVW'(int'(col) - (BLK - 1 + RNG));
            cand_y   <= MVW'(int'(row) - RNG);
            if (col == col_last) begin
               if (st == ST_PRED) st <= ST_PWAIT;
               else if (row == row_last) st <= ST_DRAIN;
               else begin
                  row <= row + 1'b1;
                  col <= col_first;
               end
            end else begin
               col <= col + 1'b1;
            end
         end
         case (st)
            ST_IDLE: if (start) begin
               s_q       <= srch_rng;
               col_first <= CW'(int'(pred_x) + RNG);
               col       <= CW'(int'(pred_x) + RNG);
               col_last  <= CW'(int'(pred_x) + RNG + BLK - 1);
               row       <= CW'(int'(pred_y) + RNG);
               st        <= ST_PRED;
            end
            ST_PWAIT: if (quiet) begin
               col_first <= CW'(RNG - int'(s_q));
               col       <= CW'(RNG - int'(s_q));
               row       <= CW'(RNG - int'(s_q));
               col_last  <= CW'(RNG + int'(s_q) + BLK - 2);
               row_last  <= CW'(RNG + int'(s_q) - 1);
               st        <= ST_SCAN;
            end
            ST_DRAIN: if (quiet) begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   et_sad_serial #(.PW(PW), .BLK(BLK), .MVW(MVW), .SW(SW)) u_ser (
      .clk(clk), .rst_n(rst_n), .init(init), .push(push),
      .push_part(part_sad), .push_x(cand_x), .push_y(cand_y),
      .push_odd(ref_odd), .cur_odd(cur_odd), .slot_full(slot_full),
      .busy(busy), .min_sad(min_sad), .best_x(best_x), .best_y(best_y));

   assign best_sad = min_sad;

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !slot_full));
   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start) |=> ($stable(best_sad) && $stable(best_x) && $stable(best_y)));
   assert_ref_in_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fetching |-> ((int'(ref_x) < WIN) && (int'(ref_y) + BLK <= WIN)));
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (cand_vld && $stable(cand_x) && $stable(cand_y)));
endmodule

// File: tb/sim_et_sad_search.sv
module sim_et_sad_search;
   localparam int PW  = 8;
   localparam int BLK = 16;
   localparam int RNG = 8;
   localparam int WIN = BLK + 2 * RNG - 1;
   localparam int XW  = $clog2(WIN);
   localparam int MVW = $clog2(RNG) + 1;
   localparam int RW  = $clog2(RNG) + 1;
   localparam int SW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic signed [MVW-1:0] pred_x = '0, pred_y = '0;
   logic [RW-1:0] srch_rng = '0;
   logic [BLK*BLK*PW-1:0] cur_blk;
   logic [XW-1:0] ref_x, ref_y;
   logic [BLK*PW-1:0] ref_col;
   logic signed [MVW-1:0] best_x, best_y;
   logic [SW-1:0] best_sad;
   logic done;

   logic [PW-1:0] win [WIN][WIN];
   logic [PW-1:0] cur [BLK][BLK];
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   et_sad_search #(.PW(PW), .BLK(BLK), .RNG(RNG)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pred_x(pred_x), .pred_y(pred_y),
      .srch_rng(srch_rng), .cur_blk(cur_blk), .ref_x(ref_x), .ref_y(ref_y),
      .ref_col(ref_col), .best_x(best_x), .best_y(best_y), .best_sad(best_sad),
      .done(done));

   always_comb begin
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++)
            cur_blk[(r*BLK+c)*PW +: PW] = cur[r][c];
   end

   always_comb begin
      for (int k = 0; k < BLK; k++)
         ref_col[k*PW +: PW] = (int'(ref_x) < WIN && int'(ref_y) + k < WIN)
                               ? win[int'(ref_x)][int'(ref_y) + k] : '0;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sad_at(input int dx, input int dy);
      int s = 0;
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++) begin
            int a = int'(cur[r][c]);
            int b = int'(win[c+dx+RNG][r+dy+RNG]);
            s += (a > b) ? a - b : b - a;
         end
      return s;
   endfunction

   task automatic fill_random();
      for (int x = 0; x < WIN; x++)
         for (int y = 0; y < WIN; y++) win[x][y] = PW'($urandom);
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++) cur[r][c] = PW'($urandom);
   endtask

   task automatic fill_motion(input int mx, input int my);
      for (int x = 0; x < WIN; x++)
         for (int y = 0; y < WIN; y++) win[x][y] = PW'($urandom);
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++) cur[r][c] = win[c+mx+RNG][r+my+RNG];
   endtask

   task automatic fill_flat(input int v);
      for (int x = 0; x < WIN; x++)
         for (int y = 0; y < WIN; y++) win[x][y] = PW'(v);
      for (int r = 0; r < BLK; r++)
         for (int c = 0; c < BLK; c++) cur[r][c] = PW'(v);
   endtask

   // one search, checked against an exhaustive model; returns cycles start->done
   task automatic verify(input string req, input int px, input int py, input int s,
                         output int cyc);
      int es, ex, ey, prev, rises, oob;
      logic [SW-1:0] hs;
      logic signed [MVW-1:0] hx, hy;
      es = sad_at(px, py); ex = px; ey = py;
      for (int dy = -s; dy < s; dy++)
         for (int dx = -s; dx < s; dx++) begin
            int v = sad_at(dx, dy);
            if (v < es) begin es = v; ex = dx; ey = dy; end
         end
      @(negedge clk);
      pred_x = MVW'(px); pred_y = MVW'(py); srch_rng = RW'(s); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1; rises = 0; oob = 0; prev = int'(best_sad);
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (int'(best_sad) > prev) rises++;
         prev = int'(best_sad);
         if (int'(ref_x) >= WIN || int'(ref_y) + BLK > WIN) oob++;
      end
      chk(done, {req, " R5 done reached"}, cyc, 0);
      chk(int'(best_sad) == es, {req, " R1 sad"}, int'(best_sad), es);
      chk(int'(best_x) == ex, {req, " R1 best_x"}, int'(best_x), ex);
      chk(int'(best_y) == ey, {req, " R1 best_y"}, int'(best_y), ey);
      chk(rises == 0, {req, " R4 minimum never rises"}, rises, 0);
      chk(oob == 0, {req, " R3 address inside window"}, oob, 0);
      hs = best_sad; hx = best_x; hy = best_y;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(!done && best_sad == hs && best_x == hx && best_y == hy,
             {req, " R5 hold after done"}, int'(best_sad), int'(hs));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R5 actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      fill_flat(0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done, "R5 reset done low", int'(done), 0);
      chk(best_sad == 16'hFFFF, "R4 reset best_sad", int'(best_sad), 65535);
      chk(best_x == 0 && best_y == 0, "R4 reset vector", int'(best_x), 0);

      // R1 R9: random frames, many survivors through the one-deep slot
      fill_random();
      verify("random s8 R9", 0, 0, 8, cyc);
      fill_random();
      verify("random corner pred R3", -8, 7, 8, cyc);
      fill_random();
      verify("random s1", 5, -2, 1, cyc);

      // R6: predicted offset is exact, every scanned candidate is dropped early
      fill_motion(3, -5);
      verify("exact pred R6", 3, -5, 8, cyc);
      chk(cyc <= 2*8*(2*8+BLK-1) + 40, "R6 early rejection length", cyc,
          2*8*(2*8+BLK-1) + 40);

      // R1: known motion found by the scan
      fill_motion(-6, 4);
      verify("motion scan", 0, 0, 8, cyc);
      chk(best_x == -6 && best_y == 4, "R1 motion vector", int'(best_x), -6);

      // R2: true motion outside a reduced range
      fill_motion(6, 6);
      verify("reduced range R2", 0, 0, 2, cyc);
      chk(int'(best_x) >= -2 && int'(best_x) <= 1 && int'(best_y) >= -2 && int'(best_y) <= 1,
          "R2 result inside range", int'(best_x), 0);

      // R7: flat frame, every score ties, prediction wins even outside range
      fill_flat(50);
      verify("flat R7", 2, -3, 8, cyc);
      chk(best_x == 2 && best_y == -3, "R7 pred wins tie", int'(best_x), 2);
      verify("flat outside range R7", -7, 6, 1, cyc);
      chk(best_x == -7 && best_y == 6, "R7 pred outside range", int'(best_y), 6);

      // R8: one bad pixel only under the prediction; earliest raster zero wins
      fill_flat(100);
      win[WIN-1][WIN-1] = '0;
      verify("raster tie R8", 7, 7, 8, cyc);
      chk(best_x == -8 && best_y == -8 && best_sad == 0, "R8 earliest of ties",
          int'(best_x), -8);
      verify("raster tie s3 R8", 7, 7, 3, cyc);
      chk(best_x == -3 && best_y == -3, "R8 earliest of ties s3", int'(best_y), -3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule